// File: doc/BRIEF.md
# Atomic Wide Counter Bridge

This block keeps a free-running counter twice as wide as the register bus that reaches it. Software sees the counter as two half-word registers. The block makes sure that two separate half-word reads, or two separate half-word writes, always see or set one consistent full-width value. A carry out of the lower half between the two accesses can never produce a torn result.

A read of the lower half returns the live lower bits. On the same clock edge it copies the live upper bits into a read-hold register, and a later read of the upper-half address returns that copy. A write to the upper-half address only stages the word in a temporary register. A later write to the lower-half address then loads the whole counter in one clock from the staged upper word and the written lower word.

A sticky flag records that the counter wrapped from all-ones to zero. Software reads the flag and clears it through a status register. Counting is gated by an enable input.

Top module: `wide_count_bridge`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `rdata` is zero and `ovf` is zero. The counter, the read-hold register and the write-stage register all reset to zero.
- R2: On each rising clock edge where `cnt_en` is high and no lower-half write occurs, the counter advances by one. While `cnt_en` is low the counter holds its value.
- R3: A read (`rd_stb` high, `wr_stb` low) at `addr` 0 puts the counter's lower half, as it was before that edge, on `rdata` one clock later. On the same edge it copies the counter's upper half into the read-hold register.
- R4: A read at `addr` 1 returns the read-hold register one clock later, not the live upper bits. A read at `addr` 1 never updates the read-hold register.
- R5: A write at `addr` 1 stores `wdata` in the write-stage register only. The counter is unchanged by it and keeps counting as `cnt_en` dictates.
- R6: A write at `addr` 0 loads the counter with {write-stage register, `wdata`} in a single clock. In that cycle the written value wins over `cnt_en`, and no increment is applied.
- R7: `ovf` sets when an increment takes the counter from all-ones to zero, and stays set until it is cleared. A write at `addr` 2 with `wdata` bit 0 equal to 1 clears it. If a wrap and a clear fall in the same cycle, the flag stays set. A lower-half write never sets the flag.
- R8: A read at `addr` 2 returns `ovf` in bit 0, with all other bits zero, one clock later.
- R9: If `rd_stb` and `wr_stb` are high in the same cycle, only the write takes effect. `rdata` keeps its value, and the read-hold register is not recaptured.
- R10: `rdata` holds its last value in cycles without a read. A read at `addr` 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counting enable |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| addr | input | 2 | Register select: 0 lower half, 1 upper half, 2 status, 3 unused |
| wdata | input | BUS_W (16) | Write data |
| rdata | output | BUS_W (16) | Registered read data, valid one clock after the read strobe |
| ovf | output | 1 | Sticky wrap flag |

## Verification
The bench builds the block with its default 16-bit half width, which makes a 32-bit counter. The wrap from all-ones to zero is reached in a few cycles by committing a value of 0xFFFFFFFE through the two-step write path, not by counting through the full range. The carry case for the atomic read is reached in the same way: the bench loads a lower half of 0xFFFF and reads while the counter is enabled, so the upper half changes between the two half-word reads. A cycle-by-cycle reference model also covers the collisions: commit against enable, wrap against clear, and a read and a write in the same cycle.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } bus_op_t;

    // A write in the same cycle suppresses the read.
    function automatic bus_op_t decode_op(input logic rd, input logic wr, input logic [1:0] a);
        bus_op_t o;
        o.rd  = rd & ~wr;
        o.wr  = wr;
        o.sel = reg_sel_e'(a);
        return o;
    endfunction

endpackage

// File: rtl/wcb_counter.sv
module wcb_counter #(
    parameter int BUS_W = 16,
    localparam int CNT_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q
);
    logic wrap;

    assign wrap = en && !load && (cnt_q == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (wrap) begin
            ovf_q <= 1'b1;
        end else if (clr) begin
            ovf_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wcb_shadow.sv
module wcb_shadow #(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic [BUS_W-1:0] cap_val,
    input  logic             stage,
    input  logic [BUS_W-1:0] stage_val,
    output logic [BUS_W-1:0] hold_q,
    output logic [BUS_W-1:0] temp_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            temp_q <= '0;
        end else begin
            if (cap)   hold_q <= cap_val;
            if (stage) temp_q <= stage_val;
        end
    end
endmodule

// File: rtl/wcb_readmux.sv
module wcb_readmux
    import wcb_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_op_t          op,
    input  logic [BUS_W-1:0] lo_val,
    input  logic [BUS_W-1:0] hold_val,
    input  logic             ovf_val,
    output logic [BUS_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (op.rd) begin
            unique case (op.sel)
                SEL_LO:   rdata_q <= lo_val;
                SEL_HI:   rdata_q <= hold_val;
                SEL_STAT: rdata_q <= {{(BUS_W-1){1'b0}}, ovf_val};
                default:  rdata_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/wide_count_bridge.sv
module wide_count_bridge
    import wcb_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             ovf
);
    localparam int CNT_W = 2 * BUS_W;

    bus_op_t          op;
    logic             do_load, do_stage, do_cap, do_clr;
    logic [CNT_W-1:0] cnt_q;
    logic [BUS_W-1:0] hold_q, temp_q;

    assign op       = decode_op(rd_stb, wr_stb, addr);
    assign do_load  = op.wr && (op.sel == SEL_LO);
    assign do_stage = op.wr && (op.sel == SEL_HI);
    assign do_clr   = op.wr && (op.sel == SEL_STAT) && wdata[0];
    assign do_cap   = op.rd && (op.sel == SEL_LO);

    wcb_counter #(.BUS_W(BUS_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en       (cnt_en),
        .load     (do_load),
        .load_val ({temp_q, wdata}),
        .clr      (do_clr),
        .cnt_q    (cnt_q),
        .ovf_q    (ovf)
    );

    wcb_shadow #(.BUS_W(BUS_W)) u_shd (
        .clk       (clk),
        .rst       (rst),
        .cap       (do_cap),
        .cap_val   (cnt_q[CNT_W-1:BUS_W]),
        .stage     (do_stage),
        .stage_val (wdata),
        .hold_q    (hold_q),
        .temp_q    (temp_q)
    );

    wcb_readmux #(.BUS_W(BUS_W)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .lo_val   (cnt_q[BUS_W-1:0]),
        .hold_val (hold_q),
        .ovf_val  (ovf),
        .rdata_q  (rdata)
    );
endmodule

// File: rtl/wcb_checker.sv
module wcb_checker #(
    parameter int BUS_W = 16,
    localparam int CNT_W = 2 * BUS_W
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_en,
    input logic             rd_stb,
    input logic             wr_stb,
    input logic [1:0]       addr,
    input logic [BUS_W-1:0] wdata,
    input logic [BUS_W-1:0] rdata,
    input logic             ovf,
    input logic [CNT_W-1:0] cnt_q,
    input logic [BUS_W-1:0] hold_q,
    input logic [BUS_W-1:0] temp_q
);
    logic rd_ok, commit, clear;
    assign rd_ok  = rd_stb && !wr_stb;
    assign commit = wr_stb && (addr == 2'd0);
    assign clear  = wr_stb && (addr == 2'd2) && wdata[0];

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !commit) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !commit) |=> $stable(cnt_q));

    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_ok && addr == 2'd0) |=> (hold_q == $past(cnt_q[CNT_W-1:BUS_W])
                                     && rdata == $past(cnt_q[BUS_W-1:0])));

    p_hold_read_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_ok && addr == 2'd1) |=> (rdata == $past(hold_q) && $stable(hold_q)));

    p_commit_r6: assert property (@(posedge clk) disable iff (rst)
        commit |=> (cnt_q == {$past(temp_q), $past(wdata)}));

    p_ovf_set_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !commit && cnt_q == {CNT_W{1'b1}}) |=> ovf);

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clear) |=> ovf);

    p_wr_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && rd_stb) |=> ($stable(rdata) && $stable(hold_q)));
endmodule

bind wide_count_bridge wcb_checker #(.BUS_W(BUS_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cnt_en (cnt_en),
    .rd_stb (rd_stb),
    .wr_stb (wr_stb),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .ovf    (ovf),
    .cnt_q  (cnt_q),
    .hold_q (hold_q),
    .temp_q (temp_q)
);

// File: tb/sim_wide_count_bridge.sv
`timescale 1ns/1ps
module sim_wide_count_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        ovf;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [31:0] m_cnt = 32'h0;
    logic [15:0] m_hold = 16'h0, m_temp = 16'h0, m_rdata = 16'h0;
    logic        m_ovf = 1'b0;

    always #2 clk = ~clk;

    wide_count_bridge #(.BUS_W(16)) u0 (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ovf(ovf)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle from a negedge, update model at the posedge, compare at next negedge.
    task automatic cyc(input logic rd, input logic wr, input logic [1:0] a,
                       input logic [15:0] d, input logic en, input string tag);
        logic [31:0] c0;
        logic [15:0] h0;
        logic        o0;
        rd_stb = rd; wr_stb = wr; addr = a; wdata = d; cnt_en = en;
        @(posedge clk);
        c0 = m_cnt; h0 = m_hold; o0 = m_ovf;
        if (wr && a == 2'd0) begin
            m_cnt = {m_temp, d};
        end else if (en) begin
            m_cnt = c0 + 32'd1;
            if (c0 == 32'hFFFF_FFFF) m_ovf = 1'b1;
        end
        if (wr && a == 2'd2 && d[0] && !(en && c0 == 32'hFFFF_FFFF && !(wr && a == 2'd0)))
            m_ovf = 1'b0;
        if (wr && a == 2'd1) m_temp = d;
        if (rd && !wr) begin
            case (a)
                2'd0: begin m_rdata = c0[15:0]; m_hold = c0[31:16]; end
                2'd1: m_rdata = h0;
                2'd2: m_rdata = {15'h0, o0};
                default: m_rdata = 16'h0;
            endcase
        end
        @(negedge clk);
        chk(tag, "rdata", {16'h0, rdata}, {16'h0, m_rdata});
        chk(tag, "ovf", {31'h0, ovf}, {31'h0, m_ovf});
        rd_stb = 1'b0; wr_stb = 1'b0; cnt_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "rdata in reset", {16'h0, rdata}, 32'h0);
        chk("R1", "ovf in reset", {31'h0, ovf}, 32'h0);
        rst = 1'b0;
        cyc(1, 0, 2'd1, 16'h0, 0, "R1");          // hold register is zero after reset
        chk("R1", "hold after reset", {16'h0, rdata}, 32'h0);
        cyc(1, 0, 2'd0, 16'h0, 0, "R1");

        for (int i = 0; i < 5; i++) cyc(0, 0, 2'd0, 16'h0, 1, "R2");
        cyc(1, 0, 2'd0, 16'h0, 1, "R3");
        chk("R3", "low after 5 counts", {16'h0, rdata}, 32'd5);
        for (int i = 0; i < 3; i++) cyc(0, 0, 2'd0, 16'h0, 0, "R2");
        cyc(1, 0, 2'd0, 16'h0, 0, "R2");
        chk("R2", "held when disabled", {16'h0, rdata}, 32'd6);

        cyc(0, 1, 2'd1, 16'h1234, 1, "R5");
        cyc(1, 0, 2'd0, 16'h0, 0, "R5");
        chk("R5", "counter not loaded by staging", {16'h0, rdata}, 32'd7);
        cyc(1, 0, 2'd1, 16'h0, 0, "R5");
        chk("R5", "upper still zero", {16'h0, rdata}, 32'h0);

        // carry between the two half reads
        cyc(0, 1, 2'd1, 16'h0005, 0, "R5");
        cyc(0, 1, 2'd0, 16'hFFFF, 1, "R6");
        cyc(1, 0, 2'd0, 16'h0, 1, "R3");
        chk("R3", "low before carry", {16'h0, rdata}, 32'h0000_FFFF);
        cyc(1, 0, 2'd1, 16'h0, 1, "R4");
        chk("R4", "upper from hold", {16'h0, rdata}, 32'h0000_0005);
        cyc(1, 0, 2'd1, 16'h0, 1, "R4");
        chk("R4", "no recapture on upper read", {16'h0, rdata}, 32'h0000_0005);
        cyc(1, 0, 2'd0, 16'h0, 0, "R3");
        cyc(1, 0, 2'd1, 16'h0, 0, "R4");
        chk("R4", "new capture", {16'h0, rdata}, 32'h0000_0006);

        // wrap and sticky flag
        cyc(0, 1, 2'd1, 16'hFFFF, 0, "R5");
        cyc(0, 1, 2'd0, 16'hFFFE, 0, "R6");
        cyc(0, 0, 2'd0, 16'h0, 1, "R7");
        chk("R7", "no flag before wrap", {31'h0, ovf}, 32'h0);
        cyc(0, 0, 2'd0, 16'h0, 1, "R7");
        chk("R7", "flag after wrap", {31'h0, ovf}, 32'h1);
        cyc(0, 0, 2'd0, 16'h0, 1, "R7");
        cyc(1, 0, 2'd2, 16'h0, 0, "R8");
        chk("R8", "status read", {16'h0, rdata}, 32'h1);
        cyc(0, 1, 2'd2, 16'h0000, 0, "R7");
        chk("R7", "bit0=0 does not clear", {31'h0, ovf}, 32'h1);
        cyc(0, 1, 2'd2, 16'h0001, 0, "R7");
        chk("R7", "cleared", {31'h0, ovf}, 32'h0);
        cyc(1, 0, 2'd2, 16'h0, 0, "R8");
        chk("R8", "status after clear", {16'h0, rdata}, 32'h0);

        // wrap and clear together: set wins
        cyc(0, 1, 2'd0, 16'hFFFF, 0, "R6");
        cyc(0, 1, 2'd2, 16'h0001, 1, "R7");
        chk("R7", "set beats clear", {31'h0, ovf}, 32'h1);
        cyc(0, 1, 2'd2, 16'h0001, 0, "R7");

        // commit beats enable at all-ones, no flag
        cyc(0, 1, 2'd0, 16'hFFFF, 0, "R6");
        cyc(0, 1, 2'd0, 16'h0000, 1, "R6");
        chk("R6", "commit does not set flag", {31'h0, ovf}, 32'h0);
        cyc(1, 0, 2'd0, 16'h0, 0, "R6");
        chk("R6", "commit value, no increment", {16'h0, rdata}, 32'h0);
        cyc(1, 0, 2'd1, 16'h0, 0, "R6");
        chk("R6", "commit upper", {16'h0, rdata}, 32'h0000_FFFF);

        // read and write together
        cyc(1, 1, 2'd1, 16'hABCD, 0, "R9");
        chk("R9", "rdata unchanged", {16'h0, rdata}, 32'h0000_FFFF);
        cyc(1, 1, 2'd0, 16'h1111, 0, "R9");
        cyc(1, 0, 2'd1, 16'h0, 0, "R9");
        chk("R9", "hold not recaptured", {16'h0, rdata}, 32'h0000_FFFF);
        cyc(1, 0, 2'd0, 16'h0, 0, "R9");
        cyc(1, 0, 2'd1, 16'h0, 0, "R9");
        chk("R9", "write took effect", {16'h0, rdata}, 32'h0000_ABCD);

        cyc(1, 0, 2'd3, 16'h0, 0, "R10");
        chk("R10", "unused address", {16'h0, rdata}, 32'h0);
        cyc(1, 0, 2'd0, 16'h0, 0, "R10");
        for (int i = 0; i < 3; i++) cyc(0, 0, 2'd0, 16'h0, 1, "R10");
        chk("R10", "rdata holds", {16'h0, rdata}, 32'h0000_1111);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule